// File: doc/BRIEF.md
# Memory Controller Event Statistics Unit

This unit sits next to a memory controller and measures its traffic. The controller presents a 32-bit vector of single-cycle event strobes, one bit per event code 0 to 31. Two event counters each watch the one strobe that their own 5-bit select field names. A third counter counts clock cycles. All three share one run gate, so software can divide an event count by the elapsed cycles to get a rate. Some codes carry fixed meanings: 8 is every read, 9 is every write, 10 is every transaction, 30 is a row activation and 31 is a precharge. The other codes are free for whatever the controller reports.

Software uses a small 32-bit register bus. It writes a control word to set the two selects, start or stop counting, and request a clear. It then polls until the clear bit drops back to zero by itself. Each 64-bit count is read as two 32-bit words. Reading the low word also latches the high word into a shadow, so the later high-word read matches the low word even while counting goes on. Read data is registered and returned one cycle after the read strobe.

Top module: `evstat_top`

## Requirements
- R1: After a synchronous reset, the control word reads 0, every counter reads 0 and the read-valid output is low.
- R2: The control word is at byte offset 0x00. Bits 4:0 select the event for counter 0, bits 12:8 select the event for counter 1, bit 16 is the clear request and bit 17 is the run enable. All other bits read 0.
- R3: While running and no clear is pending, an event counter adds exactly 1 in each cycle where the strobe bit named by its select is high. The two counters are independent and may select the same code.
- R4: A new select value first applies in the cycle after the write that carries it. The cycle of the write itself still uses the old select.
- R5: The cycle counter adds 1 on every clock edge at which the run enable is set and no clear is pending.
- R6: While the run enable is 0, all three counters hold their values whatever the strobes do.
- R7: Writing 1 to bit 16 zeroes all three counters. Bit 16 reads 1 in the cycle after the write and 0 one cycle later. No counter increments while the clear is pending.
- R8: Counter 0 is read at offsets 0x04 (low) and 0x08 (high), counter 1 at 0x0C and 0x10, and the cycle counter at 0x14 and 0x18. Read data and read-valid appear in the cycle after the read strobe.
- R9: Reading a low word latches that counter's high part into a shadow. A high-word read returns the shadow, not the live count.
- R10: Counters wrap silently from all ones to zero. The count width and the low-word width are parameters (64 and 32 by default).
- R11: Reads of unmapped or unaligned offsets return 0. Writes to any offset other than 0x00 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_rd_en | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| bus_rvalid | output | 1 | High in the cycle that bus_rdata holds a read result |
| ev_strobe | input | 32 | Event strobes, bit n is event code n |

## Verification
The assertions assume that every input has a known value from the first clock edge and that reset is held from time zero. They also assume that a control write and the clear it starts are seen only through the port strobes, and not forced into the registers. Under these conditions the counter properties hold for any strobe pattern. The stimulus drives every input from a defined value on the falling clock edge, keeps reset high for several cycles at start, and never leaves the strobe inputs undriven. The bench uses a 12-bit count split 8/4, so the high word and the wrap point can both be reached.

// File: rtl/evstat_pkg.sv
package evstat_pkg;

  localparam int SEL_W      = 5;
  localparam int EV_W       = 1 << SEL_W;
  localparam int NUM_EVCNT  = 2;
  localparam int NUM_CNT    = NUM_EVCNT + 1;
  localparam int SEL_STRIDE = 8;
  localparam int CLR_BIT    = 16;
  localparam int RUN_BIT    = 17;
  localparam int IDX_W      = $clog2(NUM_CNT);

  typedef enum logic [1:0] {
    ACC_CTRL,
    ACC_LO,
    ACC_HI,
    ACC_NONE
  } acc_kind_e;

  typedef struct packed {
    acc_kind_e          kind;
    logic [IDX_W-1:0]   idx;
  } acc_t;

  // Byte offset -> access kind and counter index.
  // Word 0 is control, words 1..2*NUM_CNT alternate low/high per counter.
  function automatic acc_t decode_ofs(input logic [7:0] ofs);
    acc_t res;
    int   w;
    res.kind = ACC_NONE;
    res.idx  = '0;
    w = int'(ofs[7:2]);
    if (ofs[1:0] == 2'b00) begin
      if (w == 0) begin
        res.kind = ACC_CTRL;
      end else if (w <= 2 * NUM_CNT) begin
        res.idx  = IDX_W'((w - 1) >> 1);
        res.kind = ((w - 1) & 1) != 0 ? ACC_HI : ACC_LO;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/evstat_ctrl.sv
module evstat_ctrl
  import evstat_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               wr_en,
  input  logic [DATA_W-1:0]                  wdata,
  output logic [NUM_EVCNT-1:0][SEL_W-1:0]    sel_q,
  output logic                               run_q,
  output logic                               clr_pend,
  output logic [DATA_W-1:0]                  ctrl_word
);

  logic unused_wbits;
  assign unused_wbits = ^wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= '0;
      run_q    <= 1'b0;
      clr_pend <= 1'b0;
    end else begin
      // clear request lives for exactly one cycle unless rewritten
      clr_pend <= wr_en ? wdata[CLR_BIT] : 1'b0;
      if (wr_en) begin
        run_q <= wdata[RUN_BIT];
        for (int k = 0; k < NUM_EVCNT; k++) begin
          sel_q[k] <= wdata[k*SEL_STRIDE +: SEL_W];
        end
      end
    end
  end

  always_comb begin
    ctrl_word = '0;
    for (int k = 0; k < NUM_EVCNT; k++) begin
      ctrl_word[k*SEL_STRIDE +: SEL_W] = sel_q[k];
    end
    ctrl_word[CLR_BIT] = clr_pend;
    ctrl_word[RUN_BIT] = run_q;
  end

  // R7
  clr_self_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_pend && !wr_en) |=> !clr_pend);

  // R2
  run_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(run_q));

  // R4
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(sel_q));

endmodule

// File: rtl/evstat_count.sv
module evstat_count #(
  parameter int CNT_W = 64,
  parameter int EV_W  = 32,
  parameter int SEL_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  input  logic [EV_W-1:0]  ev,
  output logic [CNT_W-1:0] cnt
);

  logic hit;
  assign hit = ev[sel];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (run && hit) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !clr) |=> (cnt == $past(cnt)));

  // R7
  clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));

  // R3
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !clr) |=> ((cnt - $past(cnt)) <= CNT_W'(1)));

endmodule

// File: rtl/evstat_rdmux.sv
module evstat_rdmux
  import evstat_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 64,
  parameter int LO_W   = 32
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            rd_en,
  input  acc_t                            acc,
  input  logic [DATA_W-1:0]               ctrl_word,
  input  logic [NUM_CNT-1:0][CNT_W-1:0]   cnt,
  output logic [DATA_W-1:0]               rdata,
  output logic                            rvalid
);

  localparam int HI_W = CNT_W - LO_W;

  logic [NUM_CNT-1:0][HI_W-1:0] shadow;
  logic                         lo_read;
  assign lo_read = rd_en && (acc.kind == ACC_LO);

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_shadow
    logic [HI_W-1:0] sh_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        sh_q <= '0;
      end else if (lo_read && (acc.idx == IDX_W'(g))) begin
        sh_q <= cnt[g][CNT_W-1:LO_W];
      end
    end
    assign shadow[g] = sh_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) begin
        unique case (acc.kind)
          ACC_CTRL: rdata <= ctrl_word;
          ACC_LO:   rdata <= DATA_W'(cnt[acc.idx][LO_W-1:0]);
          ACC_HI:   rdata <= DATA_W'(shadow[acc.idx]);
          default:  rdata <= '0;
        endcase
      end
    end
  end

  // R8
  rvalid_on_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rvalid);

  // R8
  rvalid_off_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rvalid);

  // R11
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && acc.kind == ACC_NONE) |=> (rdata == '0));

endmodule

// File: rtl/evstat_top.sv
module evstat_top
  import evstat_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 64,
  parameter int LO_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic [EV_W-1:0]   ev_strobe
);

  acc_t                           acc;
  logic                           ctrl_wr;
  logic [NUM_EVCNT-1:0][SEL_W-1:0] sel_q;
  logic                           run_q;
  logic                           clr_pend;
  logic [DATA_W-1:0]              ctrl_word;
  logic [NUM_CNT-1:0][CNT_W-1:0]  cnt_all;

  assign acc     = decode_ofs(8'(bus_addr));
  assign ctrl_wr = bus_wr_en && (acc.kind == ACC_CTRL);

  evstat_ctrl #(
    .DATA_W (DATA_W)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (ctrl_wr),
    .wdata     (bus_wdata),
    .sel_q     (sel_q),
    .run_q     (run_q),
    .clr_pend  (clr_pend),
    .ctrl_word (ctrl_word)
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    logic [SEL_W-1:0] sel_g;
    logic [EV_W-1:0]  ev_g;
    if (g < NUM_EVCNT) begin : g_event
      assign sel_g = sel_q[g];
      assign ev_g  = ev_strobe;
    end else begin : g_cycle
      assign sel_g = '0;
      assign ev_g  = '1;
    end
    evstat_count #(
      .CNT_W (CNT_W),
      .EV_W  (EV_W),
      .SEL_W (SEL_W)
    ) u_count (
      .clk (clk),
      .rst (rst),
      .run (run_q),
      .clr (clr_pend),
      .sel (sel_g),
      .ev  (ev_g),
      .cnt (cnt_all[g])
    );
  end

  evstat_rdmux #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .LO_W   (LO_W)
  ) u_rdmux (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (bus_rd_en),
    .acc       (acc),
    .ctrl_word (ctrl_word),
    .cnt       (cnt_all),
    .rdata     (bus_rdata),
    .rvalid    (bus_rvalid)
  );

endmodule

// File: tb/test_evstat_top.sv
module test_evstat_top;

  localparam int DW   = 32;
  localparam int AW   = 5;
  localparam int CW   = 12;
  localparam int LW   = 8;
  localparam int CMOD = 1 << CW;
  localparam logic [31:0] RUN = 32'h0002_0000;
  localparam logic [31:0] CLR = 32'h0001_0000;

  typedef struct packed {
    logic [4:0]  s0;
    logic [4:0]  s1;
    logic [31:0] seed;
    logic [15:0] len;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{5'd8,  5'd9,  32'h1357_9BDF, 16'd40},
    '{5'd30, 5'd31, 32'hFFFF_FFFF, 16'd25},
    '{5'd0,  5'd0,  32'h0000_0000, 16'd10},
    '{5'd10, 5'd10, 32'hA5A5_F00F, 16'd300},
    '{5'd31, 5'd0,  32'h8000_0001, 16'd17}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr_en = 1'b0;
  logic          bus_rd_en = 1'b0;
  logic [AW-1:0] bus_addr  = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          bus_rvalid;
  logic [31:0]   ev_strobe = '0;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  evstat_top #(
    .DATA_W (DW),
    .ADDR_W (AW),
    .CNT_W  (CW),
    .LO_W   (LW)
  ) i_evstat_top (
    .clk        (clk),
    .rst        (rst),
    .bus_wr_en  (bus_wr_en),
    .bus_rd_en  (bus_rd_en),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .ev_strobe  (ev_strobe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr_en = 1'b1;
    bus_addr  = AW'(a);
    bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
    bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd_en = 1'b1;
    bus_addr  = AW'(a);
    @(negedge clk);
    bus_rd_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd64(input int idx, output logic [31:0] v);
    logic [31:0] lo, hi;
    rd(8'(4 + 8 * idx), lo);
    rd(8'(8 + 8 * idx), hi);
    v = ((hi << LW) | lo) & 32'(CMOD - 1);
  endtask

  task automatic clear_wait();
    logic [31:0] c;
    wr(8'h00, CLR);
    for (int p = 0; p < 4; p++) begin
      rd(8'h00, c);
      if (c[16] == 1'b0) break;
    end
  endtask

  function automatic logic [31:0] pat(input logic [31:0] seed, input int i);
    if (seed == 32'h0) return 32'h0;
    if (seed == 32'hFFFF_FFFF) return 32'hFFFF_FFFF;
    return (seed * 32'(i + 1)) ^ (seed >> (i % 5)) ^ {16'(i), 16'(i * 3)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, v, c0, c1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 rvalid idle", 32'(bus_rvalid), 32'h0);
    rd(8'h00, d);
    check("R1 ctrl", d, 32'h0);
    check("R8 rvalid after read", 32'(bus_rvalid), 32'h1);
    rd64(0, v); check("R1 ev0", v, 32'h0);
    rd64(2, v); check("R1 cycles", v, 32'h0);

    // R2 control readback, undefined bits read zero
    wr(8'h00, 32'hFFFE_FFFF);
    rd(8'h00, d);
    check("R2 ctrl fields", d, 32'h0002_1F1F);
    wr(8'h00, 32'h0);

    // R7 clear self-clears, no count while pending
    wr(8'h00, CLR);
    rd(8'h00, d); check("R7 pending bit", d, CLR);
    rd(8'h00, d); check("R7 bit dropped", d, 32'h0);
    rd64(2, v);   check("R7 cycles zeroed", v, 32'h0);
    ev_strobe = 32'h1;
    wr(8'h00, RUN | CLR);
    repeat (5) @(negedge clk);
    wr(8'h00, 32'h0);
    ev_strobe = 32'h0;
    rd64(0, v); check("R7 ev0 after pending", v, 32'd5);
    rd64(2, v); check("R5 cycles after pending", v, 32'd5);

    // R3/R5 table of vectors
    foreach (VECS[k]) begin
      int e0, e1;
      clear_wait();
      wr(8'h00, RUN | (32'(VECS[k].s1) << 8) | 32'(VECS[k].s0));
      e0 = 0; e1 = 0;
      for (int i = 0; i < int'(VECS[k].len); i++) begin
        ev_strobe = pat(VECS[k].seed, i);
        if (ev_strobe[VECS[k].s0]) e0++;
        if (ev_strobe[VECS[k].s1]) e1++;
        @(negedge clk);
      end
      ev_strobe = 32'h0;
      wr(8'h00, 32'h0);
      rd64(0, v); check("R3 ev0 vector", v, 32'(e0 % CMOD));
      rd64(1, v); check("R3 ev1 vector", v, 32'(e1 % CMOD));
      rd64(2, v); check("R5 cycles vector", v, 32'((int'(VECS[k].len) + 1) % CMOD));
    end

    // R4 select takes effect one cycle after the write
    clear_wait();
    wr(8'h00, RUN | 32'd3);
    ev_strobe = 32'h20;
    wr(8'h00, RUN | 32'd5);
    @(negedge clk);
    ev_strobe = 32'h08;
    @(negedge clk);
    ev_strobe = 32'h0;
    wr(8'h00, 32'd5);
    rd64(0, v); check("R4 select timing", v, 32'd1);

    // R6 stopped counters hold
    rd64(2, c1);
    ev_strobe = 32'hFFFF_FFFF;
    repeat (10) @(negedge clk);
    ev_strobe = 32'h0;
    rd64(0, v); check("R6 ev0 frozen", v, 32'd1);
    rd64(2, v); check("R6 cycles frozen", v, c1);

    // R9 shadow and R11 ignored accesses
    clear_wait();
    wr(8'h00, RUN);
    ev_strobe = 32'h1;
    repeat (300) @(negedge clk);
    ev_strobe = 32'h0;
    wr(8'h00, 32'h0);
    rd(8'h04, d); check("R8 ev0 low", d, 32'h2C);
    wr(8'h04, 32'h0);
    wr(8'h1C, RUN);
    rd(8'h04, d); check("R11 write to low ignored", d, 32'h2C);
    rd(8'h00, d); check("R11 unmapped write ignored", d, 32'h0);
    rd(8'h1C, d); check("R11 unmapped read", d, 32'h0);
    rd(8'h02, d); check("R11 unaligned read", d, 32'h0);
    rd64(2, c0);
    clear_wait();
    rd(8'h08, d); check("R9 high from shadow", d, 32'h1);
    rd(8'h04, d); check("R9 low after clear", d, 32'h0);
    rd(8'h08, d); check("R9 high recaptured", d, 32'h0);

    // R10 wrap
    clear_wait();
    wr(8'h00, RUN);
    ev_strobe = 32'h1;
    repeat (4099) @(negedge clk);
    ev_strobe = 32'h0;
    wr(8'h00, 32'h0);
    rd64(0, v); check("R10 ev0 wrap", v, 32'd3);
    rd64(2, v); check("R10 cycles wrap", v, 32'd4);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule